// File: doc/BRIEF.md
# Byte-serial test vector sequencer

This block exercises a 128-bit block cipher core that accepts its data block and its key over two 8-bit buses. After reset, on the first enabled clock, it latches the direction select and streams a stored vector. Each vector is 16 data bytes and 16 key bytes, sent side by side, one pair per enabled cycle, with a load strobe marking every valid pair. It then waits a fixed number of cycles for the core to finish and captures 16 result bytes from the core's byte-wide output. Each captured byte is compared with a stored reference. A sticky flag records whether any comparison has failed.

The run covers a fixed count of vector sets in the chosen direction and then stops. A single-cycle done pulse ends the run, and the final flag value is valid in the same cycle. A free-running modulo-10 phase counter advances on every enabled cycle. Dropping the enable freezes the whole block, including the counter. The stored tables are computed when the design is elaborated, from a seed parameter that the instantiating bench chooses.

Top module: `tv_sequencer`

## Requirements
- R1: When `rst` is high at a clock edge, the edge leaves `data_o`, `key_o`, `load_o`, `mismatch_o`, `done_o` and `phase_o` at zero and returns the block to idle.
- R2: Each vector is sent as 16 consecutive enabled cycles with `load_o` high. Byte position p (p=0 is the most significant byte) is sent in the p-th such cycle. For vector v, `data_o` = ((SEED + 17v + 5p) mod 256) XOR (0x00 when encrypting, 0xA5 when decrypting), and `key_o` = ((3·SEED + 29v + 11p + 3) mod 256) XOR (0x0F when encrypting, 0xF0 when decrypting).
- R3: While `load_o` is low, `data_o` and `key_o` are both zero.
- R4: `enc_sel`=1 selects the encryption tables and 0 selects the decryption tables. The select is sampled on the first enabled edge after reset, and later changes have no effect until the next reset.
- R5: One run sends vectors 0 to NUM_SETS-1 in order. After the last result is captured the block halts with `load_o` low until reset.
- R6: For each vector, result byte k is sampled from `result_i` on the (LAT+k)-th enabled edge after the edge at which the device takes the last input byte.
- R7: `mismatch_o` rises on the second enabled edge after a captured byte differs from its reference, and it then stays high until reset. The reference is data+key mod 256 when encrypting and data XOR key when decrypting. `mismatch_o` stays low while every byte matches.
- R8: While `en` is low, no output or internal state changes.
- R9: `phase_o` counts enabled edges modulo 10, going from 9 back to 0.
- R10: `done_o` is high for exactly one enabled cycle. It rises on the second enabled edge after the final result byte is captured, and at that point `mismatch_o` already includes the final comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low freezes the block |
| enc_sel | input | 1 | 1 encrypt, 0 decrypt; sampled at run start |
| data_o | output | 8 | Data block byte to the device |
| key_o | output | 8 | Key byte to the device |
| load_o | output | 1 | High while a byte pair is valid |
| result_i | input | 8 | Result byte from the device |
| mismatch_o | output | 1 | Sticky comparison failure flag |
| done_o | output | 1 | One-cycle end-of-run pulse |
| phase_o | output | 4 | Modulo-10 phase count |

## Verification
The bench models a device that adds the data and key bytes when encrypting and XORs them when decrypting. It runs every vector in both directions, so that the two tables and the byte ordering are each checked against the formulas. Clean runs show that the capture latency lines up; a single corrupted byte in the middle of a vector, or in the very last byte, shows the flag timing and whether the flag sticks. One run stalls the enable part-way through a vector and flips the direction select mid-run, which separates a freeze from an advance and shows that the select is latched. A reset issued in the middle of a run shows that every output returns to zero.

// File: rtl/tvs_pkg.sv
package tvs_pkg;

  typedef enum logic [1:0] {TBL_DATA = 2'd0, TBL_KEY = 2'd1, TBL_EXP = 2'd2} tbl_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_RECV = 3'd3,
    ST_HALT = 3'd4
  } st_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic logic [7:0] pat_data(input logic [7:0] seed, input int dir,
                                          input int v, input int p);
    logic [7:0] b;
    b = 8'(int'(seed) + v * 17 + p * 5);
    return b ^ ((dir != 0) ? 8'h00 : 8'hA5);
  endfunction

  function automatic logic [7:0] pat_key(input logic [7:0] seed, input int dir,
                                         input int v, input int p);
    logic [7:0] b;
    b = 8'(int'(seed) * 3 + v * 29 + p * 11 + 3);
    return b ^ ((dir != 0) ? 8'h0F : 8'hF0);
  endfunction

  function automatic logic [7:0] tbl_byte(input tbl_e kind, input logic [7:0] seed,
                                          input int dir, input int v, input int p);
    logic [7:0] d, k;
    d = pat_data(seed, dir, v, p);
    k = pat_key(seed, dir, v, p);
    case (kind)
      TBL_DATA: return d;
      TBL_KEY:  return k;
      default:  return (dir != 0) ? 8'(d + k) : (d ^ k);
    endcase
  endfunction

endpackage

// File: rtl/tvs_rom.sv
module tvs_rom import tvs_pkg::*; #(
  parameter int         NUM_SETS = 20,
  parameter int         NBYTES   = 16,
  parameter logic [7:0] SEED     = 8'h5A,
  parameter tbl_e       KIND     = TBL_DATA
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ce,
  input  logic                        rd,
  input  logic                        dir,
  input  logic [idx_w(NUM_SETS)-1:0]  vec,
  input  logic [idx_w(NBYTES)-1:0]    pos,
  output logic [7:0]                  q
);
  localparam int VW    = idx_w(NUM_SETS);
  localparam int PW    = idx_w(NBYTES);
  localparam int AW    = 1 + VW + PW;
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      int d, v, p;
      d = a >> (VW + PW);
      v = (a >> PW) % (1 << VW);
      p = a % (1 << PW);
      if (v < NUM_SETS && p < NBYTES) mem[a] = tbl_byte(KIND, SEED, d, v, p);
      else                            mem[a] = '0;
    end
  end

  logic [AW-1:0] addr;
  assign addr = {dir, vec, pos};

  // registered read with synchronous clear; zero when not reading
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= rd ? mem[addr] : '0;
  end

endmodule

// File: rtl/tvs_ctrl.sv
module tvs_ctrl import tvs_pkg::*; #(
  parameter int NUM_SETS = 20,
  parameter int NBYTES   = 16,
  parameter int LAT      = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        enc_sel,
  output logic                        rd_o,
  output logic                        cap_o,
  output logic                        last_o,
  output logic                        dir_o,
  output logic [idx_w(NUM_SETS)-1:0]  vec_o,
  output logic [idx_w(NBYTES)-1:0]    pos_o,
  output logic                        load_o
);
  localparam int VW = idx_w(NUM_SETS);
  localparam int PW = idx_w(NBYTES);
  localparam int WW = idx_w(LAT + 1);
  localparam logic [VW-1:0] VEC_LAST = VW'(NUM_SETS - 1);
  localparam logic [PW-1:0] POS_LAST = PW'(NBYTES - 1);
  localparam logic [WW-1:0] WAIT_END = WW'(LAT - 1);

  st_e           st;
  logic [VW-1:0] vec;
  logic [PW-1:0] pos;
  logic [WW-1:0] wcnt;
  logic          dir;
  logic          load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      vec    <= '0;
      pos    <= '0;
      wcnt   <= '0;
      dir    <= 1'b0;
      load_q <= 1'b0;
    end else if (en) begin
      load_q <= (st == ST_SEND);
      case (st)
        ST_IDLE: begin
          dir <= enc_sel;
          vec <= '0;
          pos <= '0;
          st  <= ST_SEND;
        end
        ST_SEND: begin
          if (pos == POS_LAST) begin
            pos  <= '0;
            wcnt <= '0;
            st   <= ST_WAIT;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_WAIT: begin
          if (wcnt == WAIT_END) st <= ST_RECV;
          else                  wcnt <= wcnt + 1'b1;
        end
        ST_RECV: begin
          if (pos == POS_LAST) begin
            pos <= '0;
            if (vec == VEC_LAST) begin
              st <= ST_HALT;
            end else begin
              vec <= vec + 1'b1;
              st  <= ST_SEND;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assign rd_o   = (st == ST_SEND);
  assign cap_o  = (st == ST_RECV);
  assign last_o = (st == ST_RECV) && (vec == VEC_LAST) && (pos == POS_LAST);
  assign dir_o  = dir;
  assign vec_o  = vec;
  assign pos_o  = pos;
  assign load_o = load_q;

  // R8: a disabled cycle freezes the sequencing state
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(st) && $stable(vec) && $stable(pos) && $stable(dir)));

  // R5: once halted, stays halted until reset
  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT) |=> (st == ST_HALT));

  // R4: direction only moves when leaving idle
  p_dir_latched_r4: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(dir));

endmodule

// File: rtl/tvs_check.sv
module tvs_check (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       cap,
  input  logic       last,
  input  logic [7:0] result_i,
  input  logic [7:0] ref_q,
  output logic       mismatch_o,
  output logic       done_o
);
  logic       v_q;
  logic       last_q;
  logic [7:0] res_q;

  // stage 1 lines up the captured byte with the registered reference read
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      last_q <= 1'b0;
      res_q  <= '0;
    end else if (en) begin
      v_q    <= cap;
      last_q <= last;
      res_q  <= result_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch_o <= 1'b0;
      done_o     <= 1'b0;
    end else if (en) begin
      mismatch_o <= mismatch_o | (v_q && (res_q != ref_q));
      done_o     <= v_q && last_q;
    end
  end

  // R7: the failure flag never clears before reset
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |=> mismatch_o);

  // R10: done lasts one enabled cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && en) |=> !done_o);

endmodule

// File: rtl/tvs_mod10.sv
module tvs_mod10 #(
  parameter int MOD = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  output logic [$clog2(MOD)-1:0] q
);
  localparam int CW = $clog2(MOD);
  localparam logic [CW-1:0] TOP = CW'(MOD - 1);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= (q == TOP) ? '0 : q + 1'b1;
  end

  p_bound_r9: assert property (@(posedge clk) disable iff (rst) q <= TOP);

  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (en && q == TOP) |=> (q == '0));

endmodule

// File: rtl/tv_sequencer.sv
module tv_sequencer import tvs_pkg::*; #(
  parameter int         NUM_SETS = 20,
  parameter int         NBYTES   = 16,
  parameter int         LAT      = 4,
  parameter logic [7:0] SEED     = 8'h5A,
  parameter int         CNT_MOD  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       enc_sel,
  output logic [7:0]                 data_o,
  output logic [7:0]                 key_o,
  output logic                       load_o,
  input  logic [7:0]                 result_i,
  output logic                       mismatch_o,
  output logic                       done_o,
  output logic [$clog2(CNT_MOD)-1:0] phase_o
);
  localparam int VW   = idx_w(NUM_SETS);
  localparam int PW   = idx_w(NBYTES);
  localparam int NTBL = 3;

  logic          rd, cap, last, dir;
  logic [VW-1:0] vec;
  logic [PW-1:0] pos;
  logic [7:0]    tbl_q [NTBL];

  tvs_ctrl #(.NUM_SETS(NUM_SETS), .NBYTES(NBYTES), .LAT(LAT)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .enc_sel(enc_sel),
    .rd_o(rd), .cap_o(cap), .last_o(last), .dir_o(dir),
    .vec_o(vec), .pos_o(pos), .load_o(load_o)
  );

  for (genvar g = 0; g < NTBL; g++) begin : g_tbl
    localparam tbl_e K = tbl_e'(g);
    tvs_rom #(.NUM_SETS(NUM_SETS), .NBYTES(NBYTES), .SEED(SEED), .KIND(K)) u_rom (
      .clk(clk), .rst(rst), .ce(en),
      .rd((K == TBL_EXP) ? cap : rd),
      .dir(dir), .vec(vec), .pos(pos), .q(tbl_q[g])
    );
  end

  assign data_o = tbl_q[0];
  assign key_o  = tbl_q[1];

  tvs_check u_check (
    .clk(clk), .rst(rst), .en(en), .cap(cap), .last(last),
    .result_i(result_i), .ref_q(tbl_q[2]),
    .mismatch_o(mismatch_o), .done_o(done_o)
  );

  tvs_mod10 #(.MOD(CNT_MOD)) u_phase (
    .clk(clk), .rst(rst), .en(en), .q(phase_o)
  );

  // R3: buses are quiet whenever no pair is being loaded
  p_idle_bus_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !load_o |-> (data_o == 8'h00 && key_o == 8'h00));

  // R8: outputs frozen across a disabled cycle
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(data_o) && $stable(load_o) && $stable(phase_o)));

endmodule

// File: tb/tv_sequencer_tb.sv
module tv_sequencer_tb;
  localparam int         NS = 3;
  localparam int         NB = 16;
  localparam int         LT = 3;
  localparam logic [7:0] SD = 8'h21;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       enc_sel = 1'b1;
  logic [7:0] result_i = '0;
  logic [7:0] data_o, key_o;
  logic       load_o, mismatch_o, done_o;
  logic [3:0] phase_o;

  always #2 clk = ~clk;

  tv_sequencer #(.NUM_SETS(NS), .NBYTES(NB), .LAT(LT), .SEED(SD)) u_dut (
    .clk(clk), .rst(rst), .en(en), .enc_sel(enc_sel),
    .data_o(data_o), .key_o(key_o), .load_o(load_o), .result_i(result_i),
    .mismatch_o(mismatch_o), .done_o(done_o), .phase_o(phase_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // device and bookkeeping model
  bit         run_dir;
  bit         en_prev;
  int         in_cnt, in_vec, res_vec, tcount, exp_m;
  int         fault_v, fault_p, fault_age, done_age;
  bit         out_active;
  logic [7:0] buf_d [NB];
  logic [7:0] buf_k [NB];

  function automatic logic [7:0] fd(input bit dir, input int v, input int p);
    return 8'(int'(SD) + 17 * v + 5 * p) ^ (dir ? 8'h00 : 8'hA5);
  endfunction
  function automatic logic [7:0] fk(input bit dir, input int v, input int p);
    return 8'(3 * int'(SD) + 29 * v + 11 * p + 3) ^ (dir ? 8'h0F : 8'hF0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    in_cnt = 0; in_vec = 0; res_vec = 0; tcount = 0; exp_m = 0;
    fault_age = -1; done_age = -1; out_active = 0; en_prev = 0;
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rst = 1'b1; en = 1'b0;
    end
    @(negedge clk); rst = 1'b0; en = 1'b0;
    model_clear();
    chk(data_o == 0 && key_o == 0, "R1 buses after reset", {data_o, key_o}, 0);
    chk(load_o == 0, "R1 load after reset", load_o, 0);
    chk(mismatch_o == 0 && done_o == 0, "R1 flags after reset", {mismatch_o, done_o}, 0);
    chk(phase_o == 0, "R1 phase after reset", phase_o, 0);
  endtask

  task automatic cycle(input bit en_val);
    bit adv;
    @(negedge clk);
    en = en_val;
    adv = en_prev;
    if (adv) begin
      exp_m = (exp_m + 1) % 10;
      if (fault_age >= 0) fault_age++;
      if (done_age >= 0) done_age++;
      if (out_active) tcount++;
    end
    chk(phase_o == 4'(exp_m), "R9 phase count", phase_o, exp_m);
    chk(mismatch_o == (fault_age >= 2), "R6 R7 flag timing", mismatch_o, fault_age >= 2);
    chk(done_o == (done_age == 2), "R10 done timing", done_o, done_age == 2);
    if (load_o) begin
      chk(data_o == fd(run_dir, in_vec, in_cnt), "R2 R4 data byte", data_o,
          fd(run_dir, in_vec, in_cnt));
      chk(key_o == fk(run_dir, in_vec, in_cnt), "R2 R4 key byte", key_o,
          fk(run_dir, in_vec, in_cnt));
      if (en_val) begin
        buf_d[in_cnt] = data_o;
        buf_k[in_cnt] = key_o;
        in_cnt++;
        if (in_cnt == NB) begin
          in_cnt = 0; res_vec = in_vec; in_vec++;
          out_active = 1; tcount = 0;
        end
      end
    end else begin
      chk(data_o == 0 && key_o == 0, "R3 idle bus zero", {data_o, key_o}, 0);
    end
    if (out_active && tcount >= LT && tcount - LT < NB) begin
      int k;
      logic [7:0] r;
      k = tcount - LT;
      r = run_dir ? 8'(buf_d[k] + buf_k[k]) : (buf_d[k] ^ buf_k[k]);
      if (res_vec == fault_v && k == fault_p) begin
        r = r ^ 8'h01;
        if (fault_age < 0) fault_age = 0;
      end
      result_i = r;
      if (k == NB - 1) begin
        out_active = 0;
        if (res_vec == NS - 1 && done_age < 0) done_age = 0;
      end
    end
    en_prev = en_val;
  endtask

  task automatic run(input bit dir, input int fv, input int fp, input bit stall);
    bit stalled = 0;
    enc_sel = dir; run_dir = dir; fault_v = fv; fault_p = fp;
    do_reset(2);
    for (int c = 0; c < 3000 && done_age <= 4; c++) begin
      if (stall && !stalled && in_vec == 0 && in_cnt == 5) begin
        stalled = 1;
        cycle(0);
        for (int h = 0; h < 3; h++) begin
          logic [7:0] pd;
          logic [3:0] pm;
          pd = data_o; pm = phase_o;
          cycle(0);
          chk(data_o == pd && phase_o == pm && load_o == 1, "R8 frozen while disabled",
              {data_o, phase_o}, {pd, pm});
        end
      end
      if (stall && c == 30) enc_sel = ~dir;
      cycle(1);
      if (done_age > 2) chk(load_o == 0, "R5 halted after done", load_o, 0);
    end
    chk(done_age > 4, "R5 run completed", done_age, 5);
    chk(in_vec == NS, "R5 vector count", in_vec, NS);
    chk(mismatch_o == (fv >= 0), "R7 final flag", mismatch_o, fv >= 0);
  endtask

  initial begin
    model_clear();
    fault_v = -1; fault_p = -1;
    do_reset(2);
    run(1'b1, -1, -1, 1'b0);
    run(1'b0, -1, -1, 1'b1);
    run(1'b1, 1, 7, 1'b0);
    run(1'b0, NS - 1, NB - 1, 1'b0);
    // reset in the middle of a run
    enc_sel = 1'b1; run_dir = 1'b1; fault_v = -1; fault_p = -1;
    do_reset(1);
    for (int c = 0; c < 12; c++) cycle(1);
    chk(load_o == 1, "R2 mid-run load", load_o, 1);
    do_reset(1);
    for (int c = 0; c < 3; c++) cycle(0);
    chk(load_o == 0 && phase_o == 0, "R1 R8 idle after mid-run reset", {load_o, phase_o}, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule